// File: doc/BRIEF.md
# Audio Codec Serial Frame Receiver

This block turns the serial input stream of an audio codec link into parallel samples. It runs on the codec bit clock. A sync strobe marks where each 256-bit frame begins. The first 16 bits of a frame form a header. It holds a codec-ready flag and one valid tag for each of the twelve 20-bit slots that follow. The receiver keeps only the first four slots. When a slot's tag is set in the current frame, its sample goes into a holding register for that slot and the slot's status flag is raised, so a transfer agent knows a sample is waiting.

A transfer agent reads the samples by selecting a slot and pulsing a read strobe. Each sample comes back right-aligned in a 32-bit word. The read clears the slot's flags. If a new sample lands before the old one was read, the new sample replaces it and a sticky overrun flag is raised for that slot. The block also pulls a 10-bit field of active-low slot requests out of the first data slot. It hands this field to the transmit side once the frame has finished.

Top module: `acrx_frame_rx`

## Requirements
- R1: A frame starts on the first clock edge where `sync_i` is sampled high after being sampled low (this includes low during reset). The `sdata_i` value sampled on that edge is frame bit 0. A frame is 256 bits long. The header takes bits 0 to 15. Slot k (k = 1..12) takes the 20 bits ending at bit 15+20k, most significant bit first. A new sync rise in the middle of a frame restarts the count at bit 0.
- R2: Header bit 15 (the first bit sent) is the codec-ready flag. `codec_rdy_o` takes its value once the last header bit has been sampled.
- R3: Header bit 15-k is the valid tag for slot k. The holding register for slot k (k = 1..4) is written with the slot's 20 bits only if that tag is set in the same frame.
- R4: Tags and data for slots 5 to 12 have no effect on any output.
- R5: `ready_o[k-1]` is set when slot k is captured, on the edge that samples the slot's last bit, and at no other time.
- R6: `rd_data_o` combinationally shows the holding register of slot `rd_sel_i`+1 in bits 19:0, with bits 31:20 at zero. Before any capture it reads zero.
- R7: On an edge where `rd_en_i` is high, the ready flag and overrun flag of the selected slot are cleared, unless that slot is captured on the same edge.
- R8: If a slot is captured while its ready flag is set and it is not being read on that edge, the new data replaces the old and `ovr_o` for that slot is set and stays set until the slot is read. If the capture and a read of that slot fall on the same edge, the ready flag stays set and no overrun is recorded.
- R9: `tx_req_n_o` takes bits 11:2 of slot 1 whatever slot 1's tag says, and updates only on the edge that samples frame bit 255. It is active low.
- R10: While reset is held and directly after it, `ready_o` and `ovr_o` are 0, `codec_rdy_o` is 0, `tx_req_n_o` is all ones and `rd_data_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Codec bit clock; everything samples on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Frame sync strobe; a rising level marks frame bit 0 |
| sdata_i | input | 1 | Serial data from the codec |
| rd_en_i | input | 1 | Read strobe; clears the selected slot's flags |
| rd_sel_i | input | 2 | Slot select for read: 0..3 for slots 1..4 |
| rd_data_o | output | 32 | Selected sample, zero-extended |
| ready_o | output | 4 | Per-slot data-ready flags, bit 0 = slot 1 |
| ovr_o | output | 4 | Per-slot sticky overrun flags |
| codec_rdy_o | output | 1 | Codec-ready bit from the latest header |
| tx_req_n_o | output | 10 | Active-low slot requests for the transmitter |

## Verification
The assertions check four rules on every cycle. A ready flag rises only with a capture strobe. An overrun flag rises only where a ready flag was already set. A read clears the slot's flags, and a read that collides with a capture keeps the ready flag without recording an overrun. The request field changes only at the end of a frame. The bench scenarios cover the rest. They check that the right serial bits end up in the right slot with the right tag mapping and that slots 5 to 12 leave no trace. They also check that a sync rise mid-frame realigns the frame and that overwritten data and the codec-ready bit carry the values of the frame just received.

// File: rtl/acrx_pkg.sv
package acrx_pkg;
  localparam int ACRX_TAG_W      = 16;
  localparam int ACRX_SAMP_W     = 20;
  localparam int ACRX_N_CAP      = 4;
  localparam int ACRX_FRAME_BITS = 256;
  localparam int ACRX_RD_W       = 32;
  localparam int ACRX_REQ_HI     = 11;
  localparam int ACRX_REQ_LO     = 2;

  // index of the last bit of data slot k (k counts from 1)
  function automatic int acrx_slot_last(input int tag_w, input int samp_w, input int k);
    return tag_w - 1 + k * samp_w;
  endfunction
endpackage

// File: rtl/acrx_framer.sv
module acrx_framer
  import acrx_pkg::*;
#(
  parameter int FRAME_BITS = ACRX_FRAME_BITS,
  parameter int SAMP_W     = ACRX_SAMP_W,
  localparam int CNT_W     = $clog2(FRAME_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_i,
  input  logic              sdata_i,
  output logic              bit_vld,
  output logic [CNT_W-1:0]  bit_idx,
  output logic [SAMP_W-1:0] shift_nx
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BITS - 1);

  logic              sync_q;
  logic              active_q, active_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [SAMP_W-1:0] sh_q, sh_d;
  logic              sync_rise;

  assign sync_rise = sync_i & ~sync_q;

  always_comb begin
    bit_vld  = sync_rise | active_q;
    bit_idx  = sync_rise ? '0 : cnt_q;
    sh_d     = {sh_q[SAMP_W-2:0], sdata_i};
    cnt_d    = cnt_q;
    active_d = active_q;
    if (bit_vld) begin
      cnt_d    = bit_idx + 1'b1;
      active_d = (bit_idx != LAST_IDX);
    end
  end

  assign shift_nx = sh_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= 1'b0;
      active_q <= 1'b0;
      cnt_q    <= '0;
      sh_q     <= '0;
    end else begin
      sync_q   <= sync_i;
      active_q <= active_d;
      if (bit_vld) begin
        cnt_q <= cnt_d;
        sh_q  <= sh_d;
      end
    end
  end
endmodule

// File: rtl/acrx_slot_decode.sv
module acrx_slot_decode
  import acrx_pkg::*;
#(
  parameter int FRAME_BITS = ACRX_FRAME_BITS,
  parameter int TAG_W      = ACRX_TAG_W,
  parameter int SAMP_W     = ACRX_SAMP_W,
  parameter int N_CAP      = ACRX_N_CAP,
  parameter int REQ_HI     = ACRX_REQ_HI,
  parameter int REQ_LO     = ACRX_REQ_LO,
  localparam int CNT_W     = $clog2(FRAME_BITS),
  localparam int REQ_W     = REQ_HI - REQ_LO + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_vld,
  input  logic [CNT_W-1:0]  bit_idx,
  input  logic [SAMP_W-1:0] shift_nx,
  output logic [N_CAP-1:0]  cap_stb,
  output logic              frame_end,
  output logic              codec_rdy,
  output logic [REQ_W-1:0]  req_n
);
  logic             tag_end;
  logic [N_CAP-1:0] slot_end;
  logic [N_CAP-1:0] tag_q, tag_d;
  logic             cr_q, cr_d;
  logic [REQ_W-1:0] pend_q, pend_d;
  logic [REQ_W-1:0] req_q, req_d;

  assign tag_end   = bit_vld && (bit_idx == CNT_W'(TAG_W - 1));
  assign frame_end = bit_vld && (bit_idx == CNT_W'(FRAME_BITS - 1));

  for (genvar g = 0; g < N_CAP; g++) begin : g_slot
    assign slot_end[g] = bit_vld &&
      (bit_idx == CNT_W'(acrx_slot_last(TAG_W, SAMP_W, g + 1)));
    assign cap_stb[g]  = slot_end[g] & tag_q[g];
    always_comb begin
      tag_d[g] = tag_q[g];
      if (tag_end) tag_d[g] = shift_nx[TAG_W-2-g];
    end
  end

  always_comb begin
    cr_d   = cr_q;
    pend_d = pend_q;
    req_d  = req_q;
    if (tag_end)     cr_d   = shift_nx[TAG_W-1];
    if (slot_end[0]) pend_d = shift_nx[REQ_HI:REQ_LO];
    if (frame_end)   req_d  = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q  <= '0;
      cr_q   <= 1'b0;
      pend_q <= '1;
      req_q  <= '1;
    end else begin
      if (tag_end) begin
        tag_q <= tag_d;
        cr_q  <= cr_d;
      end
      if (slot_end[0]) pend_q <= pend_d;
      if (frame_end)   req_q  <= req_d;
    end
  end

  assign codec_rdy = cr_q;
  assign req_n     = req_q;
endmodule

// File: rtl/acrx_slot_bank.sv
module acrx_slot_bank
  import acrx_pkg::*;
#(
  parameter int SAMP_W = ACRX_SAMP_W,
  parameter int N_CAP  = ACRX_N_CAP
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_CAP-1:0]            cap_stb,
  input  logic [SAMP_W-1:0]           sample,
  input  logic [N_CAP-1:0]            rd_hit,
  output logic [N_CAP-1:0]            ready,
  output logic [N_CAP-1:0]            ovr,
  output logic [N_CAP-1:0][SAMP_W-1:0] hold
);
  for (genvar g = 0; g < N_CAP; g++) begin : g_cell
    logic              rdy_q, rdy_d;
    logic              ovr_q, ovr_d;
    logic [SAMP_W-1:0] hold_q;

    always_comb begin
      rdy_d = cap_stb[g] | (rdy_q & ~rd_hit[g]);
      ovr_d = rd_hit[g] ? 1'b0 : (ovr_q | (cap_stb[g] & rdy_q));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rdy_q  <= 1'b0;
        ovr_q  <= 1'b0;
        hold_q <= '0;
      end else begin
        rdy_q <= rdy_d;
        ovr_q <= ovr_d;
        if (cap_stb[g]) hold_q <= sample;
      end
    end

    assign ready[g] = rdy_q;
    assign ovr[g]   = ovr_q;
    assign hold[g]  = hold_q;
  end
endmodule

// File: rtl/acrx_frame_rx.sv
module acrx_frame_rx
  import acrx_pkg::*;
#(
  parameter int FRAME_BITS = ACRX_FRAME_BITS,
  parameter int TAG_W      = ACRX_TAG_W,
  parameter int SAMP_W     = ACRX_SAMP_W,
  parameter int N_CAP      = ACRX_N_CAP,
  parameter int RD_W       = ACRX_RD_W,
  parameter int REQ_HI     = ACRX_REQ_HI,
  parameter int REQ_LO     = ACRX_REQ_LO,
  localparam int SEL_W     = $clog2(N_CAP),
  localparam int REQ_W     = REQ_HI - REQ_LO + 1,
  localparam int CNT_W     = $clog2(FRAME_BITS)
) (
  input  logic             clk_bit,
  input  logic             rst_n,
  input  logic             sync_i,
  input  logic             sdata_i,
  input  logic             rd_en_i,
  input  logic [SEL_W-1:0] rd_sel_i,
  output logic [RD_W-1:0]  rd_data_o,
  output logic [N_CAP-1:0] ready_o,
  output logic [N_CAP-1:0] ovr_o,
  output logic             codec_rdy_o,
  output logic [REQ_W-1:0] tx_req_n_o
);
  logic                         bit_vld;
  logic [CNT_W-1:0]             bit_idx;
  logic [SAMP_W-1:0]            shift_nx;
  logic [N_CAP-1:0]             cap_stb;
  logic                         frame_end;
  logic [N_CAP-1:0]             rd_hit;
  logic [N_CAP-1:0][SAMP_W-1:0] hold;

  acrx_framer #(.FRAME_BITS(FRAME_BITS), .SAMP_W(SAMP_W)) framer_i (
    .clk(clk_bit), .rst_n(rst_n), .sync_i(sync_i), .sdata_i(sdata_i),
    .bit_vld(bit_vld), .bit_idx(bit_idx), .shift_nx(shift_nx)
  );

  acrx_slot_decode #(
    .FRAME_BITS(FRAME_BITS), .TAG_W(TAG_W), .SAMP_W(SAMP_W),
    .N_CAP(N_CAP), .REQ_HI(REQ_HI), .REQ_LO(REQ_LO)
  ) decode_i (
    .clk(clk_bit), .rst_n(rst_n), .bit_vld(bit_vld), .bit_idx(bit_idx),
    .shift_nx(shift_nx), .cap_stb(cap_stb), .frame_end(frame_end),
    .codec_rdy(codec_rdy_o), .req_n(tx_req_n_o)
  );

  for (genvar g = 0; g < N_CAP; g++) begin : g_rd
    assign rd_hit[g] = rd_en_i && (rd_sel_i == SEL_W'(g));
  end

  acrx_slot_bank #(.SAMP_W(SAMP_W), .N_CAP(N_CAP)) bank_i (
    .clk(clk_bit), .rst_n(rst_n), .cap_stb(cap_stb), .sample(shift_nx),
    .rd_hit(rd_hit), .ready(ready_o), .ovr(ovr_o), .hold(hold)
  );

  always_comb begin
    rd_data_o             = '0;
    rd_data_o[SAMP_W-1:0] = hold[rd_sel_i];
  end
endmodule

// File: rtl/acrx_frame_rx_chk.sv
module acrx_frame_rx_chk #(
  parameter int N_CAP = 4,
  parameter int REQ_W = 10,
  localparam int SEL_W = $clog2(N_CAP)
) (
  input logic             clk_bit,
  input logic             rst_n,
  input logic             rd_en_i,
  input logic [SEL_W-1:0] rd_sel_i,
  input logic [N_CAP-1:0] ready_o,
  input logic [N_CAP-1:0] ovr_o,
  input logic [N_CAP-1:0] cap_stb,
  input logic             frame_end,
  input logic [REQ_W-1:0] tx_req_n_o
);
  // R5
  ready_rise_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
    ((ready_o & ~$past(ready_o)) & ~$past(cap_stb)) == '0);

  // R8
  ovr_rise_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
    ((ovr_o & ~$past(ovr_o)) & ~$past(ready_o)) == '0);

  // R7
  rd_clear_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
    (rd_en_i && !cap_stb[rd_sel_i]) |=>
      (!ready_o[$past(rd_sel_i)] && !ovr_o[$past(rd_sel_i)]));

  // R8
  rd_collide_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
    (rd_en_i && cap_stb[rd_sel_i]) |=>
      (ready_o[$past(rd_sel_i)] && !ovr_o[$past(rd_sel_i)]));

  // R9
  req_hold_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
    !frame_end |=> $stable(tx_req_n_o));
endmodule

bind acrx_frame_rx acrx_frame_rx_chk #(.N_CAP(N_CAP), .REQ_W(REQ_W)) chk_i (
  .clk_bit(clk_bit), .rst_n(rst_n), .rd_en_i(rd_en_i), .rd_sel_i(rd_sel_i),
  .ready_o(ready_o), .ovr_o(ovr_o), .cap_stb(cap_stb),
  .frame_end(frame_end), .tx_req_n_o(tx_req_n_o)
);

// File: tb/acrx_frame_rx_tb_top.sv
module acrx_frame_rx_tb_top;
  logic        clk = 1'b0;
  logic        rst_n, sync_i, sdata_i, rd_en_i;
  logic [1:0]  rd_sel_i;
  logic [31:0] rd_data_o;
  logic [3:0]  ready_o, ovr_o;
  logic        codec_rdy_o;
  logic [9:0]  tx_req_n_o;

  always #5 clk = ~clk;

  acrx_frame_rx dut_i (
    .clk_bit(clk), .rst_n(rst_n), .sync_i(sync_i), .sdata_i(sdata_i),
    .rd_en_i(rd_en_i), .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o),
    .ready_o(ready_o), .ovr_o(ovr_o), .codec_rdy_o(codec_rdy_o),
    .tx_req_n_o(tx_req_n_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [19:0] exp_hold [4];
  logic [3:0]  exp_rdy, exp_ovr;
  logic        exp_cr;
  logic [9:0]  exp_req;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] samp(input int k, input int f);
    logic [31:0] v;
    v = f * 32'h0001_3579 + k * 32'h0002_468B + 32'h5A5;
    return v[19:0];
  endfunction

  // frame bit i; tags[11] is slot 1 ... tags[0] is slot 12
  function automatic logic fbit(input int i, input logic [11:0] tags, input logic cr, input int f);
    logic [15:0] w;
    logic [19:0] s;
    int k, p;
    if (i < 16) begin
      w = {cr, tags, 3'b000};
      return w[15-i];
    end
    k = (i - 16) / 20 + 1;
    p = 19 - ((i - 16) % 20);
    s = samp(k, f);
    return s[p];
  endfunction

  // sends nb bits of frame f; optional read of slot index rsl at bit rbit
  task automatic send(input logic [11:0] tags, input logic cr, input int f,
                      input int nb, input int rbit, input int rsl);
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      sync_i   = (i < 16);
      sdata_i  = fbit(i, tags, cr, f);
      rd_en_i  = (i == rbit);
      rd_sel_i = 2'(rsl);
      // expected effect of the edge sampling bit i
      for (int k = 1; k <= 4; k++) begin
        logic cap, rd;
        cap = tags[12-k] && (i == 15 + 20 * k);
        rd  = (i == rbit) && (rsl == k - 1);
        if (rd) exp_ovr[k-1] = 1'b0;
        if (cap && exp_rdy[k-1] && !rd) exp_ovr[k-1] = 1'b1;
        if (cap) exp_hold[k-1] = samp(k, f);
        exp_rdy[k-1] = cap | (exp_rdy[k-1] & ~rd);
      end
      if (i == 15) exp_cr = cr;
      if (i == 255) begin
        logic [19:0] s1;
        s1 = samp(1, f);
        exp_req = s1[11:2];
      end
    end
    @(negedge clk);
    sync_i  = 1'b0;
    sdata_i = 1'b0;
    rd_en_i = 1'b0;
  endtask

  task automatic rd_check(input int k, input string req);
    @(negedge clk);
    rd_en_i  = 1'b1;
    rd_sel_i = 2'(k);
    #1;
    chk(req, rd_data_o, {12'h000, exp_hold[k]});
    @(negedge clk);
    rd_en_i = 1'b0;
    exp_rdy[k] = 1'b0;
    exp_ovr[k] = 1'b0;
  endtask

  task automatic check_flags(input string req);
    chk({req, " ready"}, 32'(ready_o), 32'(exp_rdy));
    chk({req, " ovr"},   32'(ovr_o),   32'(exp_ovr));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sync_i = 1'b0; sdata_i = 1'b0; rd_en_i = 1'b0; rd_sel_i = 2'd0;
    for (int k = 0; k < 4; k++) exp_hold[k] = '0;
    exp_rdy = '0; exp_ovr = '0; exp_cr = 1'b0; exp_req = '1;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 ready", 32'(ready_o), 0);
    chk("R10 ovr", 32'(ovr_o), 0);
    chk("R10 codec_rdy", 32'(codec_rdy_o), 0);
    chk("R10 req", 32'(tx_req_n_o), 32'h3FF);
    chk("R10 rd_data", rd_data_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 post-release ready", 32'(ready_o), 0);

    // sweep every tag pattern of slots 1..4, varied tags on slots 5..12
    for (int p = 0; p < 16; p++) begin
      logic [7:0] hi;
      logic [3:0] t4;
      hi = 8'(p * 37 + 11);
      t4 = 4'(p);
      send({t4, hi}, t4[0], p + 1, 256, -1, 0);
      // t4[3] tags slot 1 -> ready bit 0
      check_flags("R3 R5");
      chk("R2 codec_rdy", 32'(codec_rdy_o), 32'(exp_cr));
      chk("R9 req", 32'(tx_req_n_o), 32'(exp_req));
      for (int k = 0; k < 4; k++) rd_check(k, "R6 R3 read word");
      check_flags("R7 after reads");
    end

    // slots 5..12 only: nothing may change
    send(12'h0FF, 1'b1, 40, 256, -1, 0);
    chk("R4 ready untouched", 32'(ready_o), 0);
    for (int k = 0; k < 4; k++) rd_check(k, "R4 hold untouched");

    // overrun: fill all, then overwrite slots 1 and 3 unread
    send(12'hF00, 1'b0, 50, 256, -1, 0);
    send(12'hA00, 1'b1, 51, 256, -1, 0);
    chk("R8 ovr set", 32'(ovr_o), 32'h5);
    check_flags("R8 overwrite");
    rd_check(0, "R8 new data on slot 1");
    check_flags("R7 clears ovr");
    for (int k = 1; k < 4; k++) rd_check(k, "R8 drain");
    chk("R8 ovr cleared", 32'(ovr_o), 0);

    // read collides with capture of slot 2 (last bit 55)
    send(12'hF00, 1'b0, 60, 256, -1, 0);
    send(12'hF00, 1'b0, 61, 256, 55, 1);
    chk("R8 collide ovr", 32'(ovr_o), 32'hD);
    chk("R8 collide ready", 32'(ready_o), 32'hF);
    check_flags("R8 collide");
    // read of slot 3 mid-frame, away from its capture
    send(12'h400, 1'b1, 62, 256, 100, 2);
    check_flags("R7 mid-frame read");
    for (int k = 0; k < 4; k++) rd_check(k, "R8 collide data");

    // realignment: truncated frame then a fresh sync rise
    send(12'hF00, 1'b1, 70, 30, -1, 0);
    chk("R9 req unchanged by partial frame", 32'(tx_req_n_o), 32'(exp_req));
    chk("R1 no capture in partial frame", 32'(ready_o), 0);
    send(12'h900, 1'b0, 71, 256, -1, 0);
    check_flags("R1 realigned");
    chk("R1 codec_rdy", 32'(codec_rdy_o), 32'(exp_cr));
    chk("R1 req", 32'(tx_req_n_o), 32'(exp_req));
    for (int k = 0; k < 4; k++) rd_check(k, "R1 realigned data");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule